// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic core of a small stored-program machine. It holds a single 8-bit accumulator and four condition flags: carry, overflow, negative and zero. On each rising clock edge where the enable input is high, it combines the accumulator with a byte taken from the data bus. A two-bit function select chooses the operation: add, subtract, load or bitwise AND. The result is written back into the accumulator, and the flags are updated according to rules that depend on the operation.

The accumulator value is always visible on a data-out port. A separate bus-drive request passes straight through to a drive-enable output, so the surrounding bus logic decides when the value actually reaches the shared bus. Subtraction adds the inverted operand with a carry-in of one. The carry flag after a subtraction is therefore the adder carry-out, where 1 means no borrow occurred. The instruction sequencer asserts the enable only in the execute cycle of an arithmetic or load instruction.

Top module: `acc_alu_core`

## Requirements
- R1: While rst_ni is low, the accumulator and all four flags are 0, whatever the clock is doing.
- R2: On a clock edge with en_i low, the accumulator and all four flags keep their values.
- R3: With fn_sel_i = 2'b00 (add) and en_i high, the accumulator becomes (A + D) mod 256, where D is the byte on bus_i. The carry flag takes the carry out of bit 7. The overflow flag is set exactly when A and D have the same sign bit and the result's sign bit differs from it.
- R4: With fn_sel_i = 2'b01 (subtract) and en_i high, the accumulator becomes (A + ~D + 1) mod 256. The carry flag takes the carry out of that sum. The overflow flag is set exactly when the carries into and out of bit 7 differ.
- R5: With fn_sel_i = 2'b10 (load) and en_i high, the accumulator takes D, and the carry and overflow flags keep their values.
- R6: With fn_sel_i = 2'b11 (AND) and en_i high, the accumulator becomes A & D, and the carry and overflow flags keep their values.
- R7: After any enabled edge, the zero flag is 1 exactly when the new accumulator is 0, and the negative flag equals bit 7 of the new accumulator.
- R8: acc_o shows the accumulator at all times, and drive_o equals drive_en_i in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Update enable for the accumulator and flags |
| fn_sel_i | input | 2 | Function select: 00 add, 01 subtract, 10 load, 11 AND |
| drive_en_i | input | 1 | Request to drive the accumulator onto the bus |
| bus_i | input | 8 | Operand byte taken from the data bus |
| acc_o | output | 8 | Current accumulator value |
| drive_o | output | 1 | Bus drive enable for acc_o |
| carry_o | output | 1 | Carry flag |
| ovf_o | output | 1 | Signed overflow flag |
| neg_o | output | 1 | Negative flag |
| zero_o | output | 1 | Zero flag |

## Verification
The embedded properties check the following on every cycle:
- the hold behaviour when the enable is low;
- that load and AND preserve the carry and overflow flags;
- that a load captures the bus byte;
- that the zero and negative flags agree with the freshly written accumulator;
- that the overflow of the adder agrees with the sign-comparison rule.

The actual arithmetic values need the bench's scenarios. That covers add and subtract results with their carry-out, the boundary sums 0x7F+1 and 0xFF+1, the subtraction 0x80-1, and subtracting equal values. It also covers an asynchronous reset arriving in the middle of a sequence, and the chains of operations in which a stale carry or overflow must survive a later load or AND.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [1:0] {
    FN_ADD  = 2'b00,
    FN_SUB  = 2'b01,
    FN_LOAD = 2'b10,
    FN_AND  = 2'b11
  } alu_fn_e;
endpackage

// File: rtl/acc_adder.sv
module acc_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   cy;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign cy[0] = sub_i;

  // ripple chain; the carry into the sign bit is needed for overflow
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic p, g;
    assign p         = a_i[i] ^ b_eff[i];
    assign g         = a_i[i] & b_eff[i];
    assign sum_o[i]  = p ^ cy[i];
    assign cy[i+1]   = g | (p & cy[i]);
  end

  assign cout_o = cy[WIDTH];
  assign ovf_o  = cy[WIDTH] ^ cy[MSB];

  // carry-based overflow must match the operand/result sign rule
  always_comb begin
    assert_sign_ovf_R4: assert (ovf_o ==
      ((a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB])))
      else $error("overflow disagrees with sign rule");
  end
endmodule

// File: rtl/acc_result_sel.sv
module acc_result_sel
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_fn_e          fn_i,
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] opnd_i,
  input  logic [WIDTH-1:0] sum_i,
  input  logic             cout_i,
  input  logic             ovf_i,
  input  logic             c_q_i,
  input  logic             v_q_i,
  output logic [WIDTH-1:0] res_o,
  output logic             c_nx_o,
  output logic             v_nx_o
);
  always_comb begin
    res_o  = sum_i;
    c_nx_o = c_q_i;
    v_nx_o = v_q_i;
    unique case (fn_i)
      FN_ADD, FN_SUB: begin
        res_o  = sum_i;
        c_nx_o = cout_i;
        v_nx_o = ovf_i;
      end
      FN_LOAD: res_o = opnd_i;
      FN_AND:  res_o = acc_i & opnd_i;
      default: res_o = sum_i;
    endcase
  end
endmodule

// File: rtl/acc_state_reg.sv
module acc_state_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [WIDTH-1:0] res_i,
  input  logic             c_nx_i,
  input  logic             v_nx_i,
  output logic [WIDTH-1:0] acc_q_o,
  output logic             c_q_o,
  output logic             v_q_o,
  output logic             n_q_o,
  output logic             z_q_o
);
  localparam int MSB = WIDTH - 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q_o <= '0;
      c_q_o   <= 1'b0;
      v_q_o   <= 1'b0;
      n_q_o   <= 1'b0;
      z_q_o   <= 1'b0;
    end else if (en_i) begin
      acc_q_o <= res_i;
      c_q_o   <= c_nx_i;
      v_q_o   <= v_nx_i;
      n_q_o   <= res_i[MSB];
      z_q_o   <= (res_i == '0);
    end
  end

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable({acc_q_o, c_q_o, v_q_o, n_q_o, z_q_o}));

  assert_nz_track_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (z_q_o == (acc_q_o == '0)) && (n_q_o == acc_q_o[MSB]));
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       fn_sel_i,
  input  logic             drive_en_i,
  input  logic [WIDTH-1:0] bus_i,
  output logic [WIDTH-1:0] acc_o,
  output logic             drive_o,
  output logic             carry_o,
  output logic             ovf_o,
  output logic             neg_o,
  output logic             zero_o
);
  alu_fn_e          fn;
  logic [WIDTH-1:0] sum, res, acc_q;
  logic             cout, add_ovf, c_nx, v_nx;
  logic             c_q, v_q, n_q, z_q;

  assign fn = alu_fn_e'(fn_sel_i);

  acc_adder #(.WIDTH(WIDTH)) u_adder (
    .a_i    (acc_q),
    .b_i    (bus_i),
    .sub_i  (fn == FN_SUB),
    .sum_o  (sum),
    .cout_o (cout),
    .ovf_o  (add_ovf)
  );

  acc_result_sel #(.WIDTH(WIDTH)) u_sel (
    .fn_i   (fn),
    .acc_i  (acc_q),
    .opnd_i (bus_i),
    .sum_i  (sum),
    .cout_i (cout),
    .ovf_i  (add_ovf),
    .c_q_i  (c_q),
    .v_q_i  (v_q),
    .res_o  (res),
    .c_nx_o (c_nx),
    .v_nx_o (v_nx)
  );

  acc_state_reg #(.WIDTH(WIDTH)) u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .res_i   (res),
    .c_nx_i  (c_nx),
    .v_nx_i  (v_nx),
    .acc_q_o (acc_q),
    .c_q_o   (c_q),
    .v_q_o   (v_q),
    .n_q_o   (n_q),
    .z_q_o   (z_q)
  );

  assign acc_o   = acc_q;
  assign drive_o = drive_en_i;
  assign carry_o = c_q;
  assign ovf_o   = v_q;
  assign neg_o   = n_q;
  assign zero_o  = z_q;

  assert_load_capture_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && fn_sel_i == 2'b10) |=> (acc_o == $past(bus_i)) && $stable({carry_o, ovf_o}));

  assert_and_keeps_cv_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && fn_sel_i == 2'b11) |=> $stable({carry_o, ovf_o}));

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (acc_o == '0) && !carry_o && !ovf_o && !neg_o && !zero_o);
endmodule

// File: tb/sim_acc_alu_core.sv
module sim_acc_alu_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] fn = 2'b00;
  logic       drv_en = 1'b0;
  logic [7:0] bus = 8'h00;
  logic [7:0] acc;
  logic       drv, c, v, n, z;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [7:0] m_acc;
  logic       m_c, m_v, m_n, m_z;

  always #4 clk = ~clk;

  acc_alu_core u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .fn_sel_i(fn),
    .drive_en_i(drv_en), .bus_i(bus), .acc_o(acc), .drive_o(drv),
    .carry_o(c), .ovf_o(v), .neg_o(n), .zero_o(z)
  );

  function automatic logic [9:0] ref_arith(input logic [7:0] a,
                                            input logic [7:0] d,
                                            input logic sub);
    logic [7:0] b;
    logic [8:0] s;
    logic       ov;
    b  = sub ? ~d : d;
    s  = {1'b0, a} + {1'b0, b} + {8'd0, sub};
    ov = (a[7] == b[7]) && (s[7] != a[7]);
    return {ov, s};
  endfunction

  task automatic model_step(input logic e, input logic [1:0] f, input logic [7:0] d);
    logic [9:0] r;
    if (!e) return;
    case (f)
      2'b00: begin r = ref_arith(m_acc, d, 1'b0); m_acc = r[7:0]; m_c = r[8]; m_v = r[9]; end
      2'b01: begin r = ref_arith(m_acc, d, 1'b1); m_acc = r[7:0]; m_c = r[8]; m_v = r[9]; end
      2'b10: m_acc = d;
      default: m_acc = m_acc & d;
    endcase
    m_n = m_acc[7];
    m_z = (m_acc == 8'h00);
  endtask

  task automatic check(input string tag);
    n_chk++;
    if (acc !== m_acc || c !== m_c || v !== m_v || n !== m_n || z !== m_z || drv !== drv_en) begin
      n_bad++;
      $display("FAIL %s: acc=%h c=%b v=%b n=%b z=%b drv=%b expected acc=%h c=%b v=%b n=%b z=%b drv=%b",
               tag, acc, c, v, n, z, drv, m_acc, m_c, m_v, m_n, m_z, drv_en);
    end
  endtask

  task automatic step(input logic e, input logic [1:0] f, input logic [7:0] d,
                      input logic de, input string tag);
    @(negedge clk);
    en = e; fn = f; bus = d; drv_en = de;
    @(posedge clk);
    model_step(e, f, d);
    #1;
    check(tag);
  endtask

  task automatic model_clear();
    m_acc = 8'h00; m_c = 0; m_v = 0; m_n = 0; m_z = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    #1 check("R1 reset state");
    @(negedge clk) rst_n = 1'b1;

    // directed corner cases
    step(1, 2'b10, 8'h7F, 0, "R5 load 7F");
    step(1, 2'b00, 8'h01, 1, "R3 7F+1 overflow");
    step(1, 2'b10, 8'h10, 0, "R5 load keeps V");
    step(1, 2'b10, 8'hFF, 0, "R5 load FF");
    step(1, 2'b00, 8'h01, 0, "R3 FF+1 carry zero R7");
    step(1, 2'b11, 8'hF0, 1, "R6 AND keeps C");
    step(1, 2'b10, 8'h80, 0, "R5 load 80");
    step(1, 2'b01, 8'h01, 0, "R4 80-1 overflow");
    step(1, 2'b01, 8'h7F, 0, "R4 equal sub zero carry");
    step(1, 2'b01, 8'h01, 0, "R4 0-1 borrow R7 neg");
    step(0, 2'b10, 8'h55, 1, "R2 hold when disabled");
    step(0, 2'b00, 8'hAA, 0, "R2 hold on add");
    step(1, 2'b11, 8'h0F, 1, "R6 AND low nibble");
    step(1, 2'b11, 8'h00, 0, "R6 AND to zero R7");

    // async reset in mid-sequence
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1 model_clear();
    check("R1 async reset");
    @(negedge clk) rst_n = 1'b1;

    // random mix
    void'($urandom(32'd2718));
    for (int i = 0; i < 600; i++) begin
      logic       e;
      logic [1:0] f;
      logic [7:0] d;
      e = ($urandom % 8) != 0;
      f = 2'($urandom);
      d = 8'($urandom);
      step(e, f, d, 1'($urandom), "R3 R4 R5 R6 R7 R8 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule